// File: doc/BRIEF.md
# Field-Encoded Integer ALU

A purely combinational 32-bit integer arithmetic and logic unit for a small in-order processor core. It takes two operands and a 4-bit operation code, evaluates all ten supported operations side by side, and drives out the result the code selects. The output has no flags and holds no state.

The code needs almost no decode. Bit 3 is the second-highest bit of the instruction's funct7 field, which is instruction bit 30. Bits 2:0 are the funct3 field. The decoder wires those four bits across for register-register operations. For immediate forms it passes bit 30 only for the right shifts and forces it low otherwise. Codes outside the ten supported ones give a result of zero, so a stray code cannot leak a partial result into writeback.

Top module: `field_alu`

## Requirements
- R1: Code 4'b0000 (addition) drives the sum of the operands modulo 2^32. A carry out of bit 31 is dropped.
- R2: Code 4'b1000 (subtraction) drives operand A minus operand B modulo 2^32.
- R3: Code 4'b0010 (signed less-than) compares the operands as two's complement. It drives 32'd1 when A < B and 32'd0 otherwise.
- R4: Code 4'b0011 (unsigned less-than) compares the operands as unsigned. It drives 32'd1 when A < B and 32'd0 otherwise.
- R5: Code 4'b0111 drives bitwise AND, code 4'b0110 drives bitwise OR, and code 4'b0100 drives bitwise XOR.
- R6: Code 4'b0001 (left shift) shifts A left by B[4:0] and fills the vacated low bits with zeros.
- R7: Code 4'b0101 (logical right shift) shifts A right by B[4:0] and fills the vacated high bits with zeros.
- R8: Code 4'b1101 (arithmetic right shift) shifts A right by B[4:0] and fills the vacated high bits with A[31].
- R9: The six codes 4'b1001, 4'b1010, 4'b1011, 4'b1100, 4'b1110 and 4'b1111 each drive 32'd0.
- R10: For the three shift codes, B[31:5] has no effect on the result.
- R11: The result depends only on the present inputs. It settles in the same cycle the inputs change and carries no value over from earlier inputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 32 | First operand; the value that is shifted for shift codes |
| op_b | input | 32 | Second operand; bits 4:0 give the shift distance |
| op_sel | input | 4 | Operation code: instruction bit 30, then funct3 |
| result | output | 32 | Result of the selected operation |

## Verification
Two functions always see the same operands in the same cycle. The first pair is signed and unsigned less-than. The bench feeds them operands whose top bits differ, such as 0x80000000 against 1, where the two comparisons must return opposite answers. Each answer is judged against a comparison the bench computes separately for that signedness. The second pair is the logical and arithmetic right shifts, which differ only in bit 30 of the code. Both are run on a negative operand at every shift distance, with junk in the upper bits of B. The fill bits of each result are checked against the bench's bit-by-bit model.

// File: rtl/field_alu.sv
module field_alu #(
  parameter int DW = 32
) (
  input  logic [DW-1:0] op_a,
  input  logic [DW-1:0] op_b,
  input  logic [3:0]    op_sel,
  output logic [DW-1:0] result
);
  localparam int SW = $clog2(DW);

  localparam logic [3:0] OP_ADD  = 4'b0000;
  localparam logic [3:0] OP_SUB  = 4'b1000;
  localparam logic [3:0] OP_SLT  = 4'b0010;
  localparam logic [3:0] OP_SLTU = 4'b0011;
  localparam logic [3:0] OP_AND  = 4'b0111;
  localparam logic [3:0] OP_OR   = 4'b0110;
  localparam logic [3:0] OP_XOR  = 4'b0100;
  localparam logic [3:0] OP_SLL  = 4'b0001;
  localparam logic [3:0] OP_SRL  = 4'b0101;
  localparam logic [3:0] OP_SRA  = 4'b1101;

  logic [SW-1:0] shamt;
  logic [DW-1:0] sum_q, diff_q, and_q, or_q, xor_q, sll_q, srl_q, sra_q;
  logic          lt_s, lt_u;

  assign shamt  = op_b[SW-1:0];
  assign sum_q  = op_a + op_b;
  assign diff_q = op_a - op_b;
  assign lt_s   = $signed(op_a) < $signed(op_b);
  assign lt_u   = op_a < op_b;
  assign and_q  = op_a & op_b;
  assign or_q   = op_a | op_b;
  assign xor_q  = op_a ^ op_b;
  assign sll_q  = op_a << shamt;
  assign srl_q  = op_a >> shamt;
  assign sra_q  = DW'($signed(op_a) >>> shamt);

  always_comb begin
    logic [DW-1:0] r;
    unique case (op_sel)
      OP_ADD:  r = sum_q;
      OP_SUB:  r = diff_q;
      OP_SLT:  r = DW'(lt_s);
      OP_SLTU: r = DW'(lt_u);
      OP_AND:  r = and_q;
      OP_OR:   r = or_q;
      OP_XOR:  r = xor_q;
      OP_SLL:  r = sll_q;
      OP_SRL:  r = srl_q;
      OP_SRA:  r = sra_q;
      default: r = '0;
    endcase
    result = r;

    // Checks sit in the same process as the mux so they see settled values.
    if (op_sel == OP_ADD)
      a_r1_add_inverse: assert (r - op_b == op_a);
    if (op_sel == OP_SUB)
      a_r2_sub_inverse: assert (r + op_b == op_a);
    if (op_sel == OP_SLT || op_sel == OP_SLTU)
      a_r3_r4_compare_is_bit: assert (r[DW-1:1] == '0);
    if ((op_sel == OP_SLT || op_sel == OP_SLTU) && op_a == op_b)
      a_r3_r4_equal_not_less: assert (r == '0);
    if (op_sel == OP_SRL && shamt != '0)
      a_r7_srl_top_zero: assert (r[DW-1] == 1'b0);
    if (op_sel == OP_SRA)
      a_r8_sra_keeps_sign: assert (r[DW-1] == op_a[DW-1]);
    if (op_sel == OP_SLL && shamt != '0)
      a_r6_sll_low_zero: assert (r[0] == 1'b0);
    if (op_sel inside {4'b1001, 4'b1010, 4'b1011, 4'b1100, 4'b1110, 4'b1111})
      a_r9_unused_zero: assert (r == '0);
  end
endmodule

// File: tb/field_alu_bench.sv
module field_alu_bench;
  logic        clk = 1'b0;
  logic [31:0] a, b;
  logic [3:0]  op;
  logic [31:0] res;
  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  field_alu u_field_alu (.op_a(a), .op_b(b), .op_sel(op), .result(res));

  function automatic logic [31:0] model(input logic [3:0] o, input logic [31:0] x, input logic [31:0] y);
    logic [31:0] m;
    int sh;
    sh = int'(y[4:0]);
    m = 32'd0;
    case (o)
      4'b0000: m = x + y;
      4'b1000: m = x + ~y + 32'd1;
      4'b0010: begin
        if (x[31] != y[31]) m = {31'd0, x[31]};
        else m = {31'd0, x < y};
      end
      4'b0011: m = {31'd0, x < y};
      4'b0111: for (int i = 0; i < 32; i++) m[i] = x[i] & y[i];
      4'b0110: for (int i = 0; i < 32; i++) m[i] = x[i] | y[i];
      4'b0100: for (int i = 0; i < 32; i++) m[i] = x[i] != y[i];
      4'b0001: for (int i = 0; i < 32; i++) m[i] = (i >= sh) ? x[i-sh] : 1'b0;
      4'b0101: for (int i = 0; i < 32; i++) m[i] = (i + sh < 32) ? x[i+sh] : 1'b0;
      4'b1101: for (int i = 0; i < 32; i++) m[i] = (i + sh < 32) ? x[i+sh] : x[31];
      default: m = 32'd0;
    endcase
    return m;
  endfunction

  task automatic apply(input logic [3:0] o, input logic [31:0] x, input logic [31:0] y, input string req);
    logic [31:0] exp;
    @(posedge clk);
    op = o; a = x; b = y;
    @(negedge clk);
    exp = model(o, x, y);
    checks++;
    if (res !== exp) begin
      fails++;
      $display("FAIL %s op=%b a=%h b=%h actual=%h expected=%h", req, o, x, y, res, exp);
    end
  endtask

  task automatic t_add_sub;
    apply(4'b0000, 32'h0000_0005, 32'h0000_0007, "R1");
    apply(4'b0000, 32'hFFFF_FFFF, 32'h0000_0001, "R1");
    apply(4'b0000, 32'h7FFF_FFFF, 32'h7FFF_FFFF, "R1");
    apply(4'b1000, 32'h0000_0003, 32'h0000_0005, "R2");
    apply(4'b1000, 32'h8000_0000, 32'h0000_0001, "R2");
    apply(4'b1000, 32'h1234_5678, 32'h1234_5678, "R2");
  endtask

  task automatic t_compare;
    logic [31:0] v [6] = '{32'h0, 32'h1, 32'h7FFF_FFFF, 32'h8000_0000, 32'hFFFF_FFFF, 32'h8000_0001};
    for (int i = 0; i < 6; i++)
      for (int j = 0; j < 6; j++) begin
        apply(4'b0010, v[i], v[j], "R3");
        apply(4'b0011, v[i], v[j], "R4");
      end
  endtask

  task automatic t_logic;
    apply(4'b0111, 32'hF0F0_AAAA, 32'hFF00_5555, "R5");
    apply(4'b0110, 32'hF0F0_AAAA, 32'hFF00_5555, "R5");
    apply(4'b0100, 32'hF0F0_AAAA, 32'hFF00_5555, "R5");
    apply(4'b0100, 32'hDEAD_BEEF, 32'hDEAD_BEEF, "R5");
  endtask

  task automatic t_shifts;
    for (int s = 0; s < 32; s++) begin
      apply(4'b0001, 32'h8000_0001, 32'(s), "R6");
      apply(4'b0101, 32'h8765_4321, 32'(s), "R7");
      apply(4'b1101, 32'h8765_4321, 32'(s), "R8");
      apply(4'b1101, 32'h4765_4321, 32'(s), "R8");
      apply(4'b0101, 32'hF000_000F, 32'hFFFF_FFE0 | 32'(s), "R10");
      apply(4'b1101, 32'hF000_000F, 32'hA5A5_A5A0 | 32'(s), "R10");
      apply(4'b0001, 32'hF000_000F, 32'h1234_5660 | 32'(s), "R10");
    end
  endtask

  task automatic t_unused;
    logic [3:0] u [6] = '{4'b1001, 4'b1010, 4'b1011, 4'b1100, 4'b1110, 4'b1111};
    for (int i = 0; i < 6; i++) begin
      apply(u[i], 32'hFFFF_FFFF, 32'h0000_0003, "R9");
      apply(u[i], 32'h8000_0000, 32'hFFFF_FFFF, "R9");
    end
  endtask

  task automatic t_no_memory;
    apply(4'b0000, 32'hFFFF_0000, 32'h0000_FFFF, "R11");
    apply(4'b0111, 32'h0000_0000, 32'h0000_0000, "R11");
    apply(4'b0000, 32'h0000_0000, 32'h0000_0000, "R11");
    apply(4'b1101, 32'h8000_0000, 32'h0000_001F, "R11");
  endtask

  initial begin
    #100000;
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    a = '0; b = '0; op = '0;
    @(negedge clk);
    checks++;
    if (res !== 32'd0) begin
      fails++;
      $display("FAIL R1 idle actual=%h expected=%h", res, 32'd0);
    end
    t_add_sub();
    t_compare();
    t_logic();
    t_shifts();
    t_unused();
    t_no_memory();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule